// File: doc/BRIEF.md
# Multi-cycle processor control sequencer (single read port register file)

This block is the main control state machine of a multi-cycle 32-bit load/store processor whose register file has one read port only. It watches the 6-bit opcode field held in the instruction register. In every cycle it drives the datapath steering signals: the memory strobes and address select, the instruction register and PC loads, the PC source, the ALU operand selects, the ALU operation class, and the register-file write controls. Two more outputs pick which source register index feeds the single read port and load the A and B operand latches one at a time.

Because only one register can be read per cycle, decode takes two cycles. The first cycle reads the rs field into A. The second reads the rt field into B, and in the same cycle the ALU forms the branch target (PC plus the shifted immediate) into the ALU output register. Load word needs only rs, so it leaves decode after the first cycle. All other instructions go through both cycles before the state machine branches on the opcode. Every control output is taken straight from a flip-flop, so each one is settled from the start of its cycle.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch step. The fetch control pattern is on the outputs in the cycle after the reset edge, and it stays there for the first cycle after reset is released.
- R2: The fetch step asserts mem_rd, ir_load and pc_load. It drives addr_sel=0 (PC), alu_a_sel=0 (PC), alu_b_sel=01 (constant 4), alu_op=00 (add) and pc_src=00 (ALU result). Every other output is 0.
- R3: The step after fetch is the first decode step. It asserts only a_load, with rd_idx_sel=0 (rs field). All other outputs are 0.
- R4: The second decode step asserts b_load with rd_idx_sel=1 (rt field). It drives alu_a_sel=0, alu_b_sel=11 (shifted sign-extended immediate) and alu_op=00. Every opcode except load word (100011) passes through this step.
- R5: Load word (100011) goes from the first decode step straight to the address step. The address step drives alu_a_sel=1, alu_b_sel=10 (sign-extended immediate) and alu_op=00. Then comes a read step with mem_rd=1 and addr_sel=1 (ALU output). Then comes a write-back step with rf_wr=1, rf_dst_sel=0 (rt) and rf_wdata_sel=1 (memory data). After that the sequencer returns to fetch.
- R6: Store word (101011) runs second decode, then the address step as in R5, then a step with mem_wr=1 and addr_sel=1. After that the sequencer returns to fetch.
- R7: R-type (000000) runs second decode, then an execute step with alu_a_sel=1, alu_b_sel=00 and alu_op=10 (function field). Then comes a write-back step with rf_wr=1, rf_dst_sel=1 (rd) and rf_wdata_sel=0 (ALU output). After that the sequencer returns to fetch.
- R8: Branch-equal (000100) runs second decode, then one step with alu_a_sel=1, alu_b_sel=00, alu_op=01 (subtract), pc_load_cond=1 and pc_src=01 (ALU output register). After that the sequencer returns to fetch.
- R9: Jump (000010) runs second decode, then one step with pc_load=1 and pc_src=10 (jump target). After that the sequencer returns to fetch.
- R10: Any other opcode goes from second decode straight back to fetch, and no memory, register-file or PC write is asserted along the way.
- R11: In every step, each output that the step does not name is 0. mem_rd and mem_wr are never asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_cond | output | 1 | PC load qualified by ALU zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 A latch |
| alu_b_sel | output | 2 | ALU operand B: 00 B latch, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 by function field |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination index: 0 rt, 1 rd |
| rf_wdata_sel | output | 1 | Write data: 0 ALU output register, 1 memory data |
| rd_idx_sel | output | 1 | Read port index: 0 rs, 1 rt |
| a_load | output | 1 | Load A latch from read port |
| b_load | output | 1 | Load B latch from read port |

## Verification
Instructions of all five supported kinds are run back to back, and the complete control word is compared in every cycle. This separates the load path, which skips the rt read, from the four paths that take it, and it shows that each path hands back to fetch after the right number of steps. Two illegal opcodes are used: one that differs from R-type in a single bit and one with all bits set. They show that an unknown code reaches fetch without any write strobe. A reset raised during a load's memory read shows that the sequence is cut off and fetch is restored at once.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH    = 4'd0,
    S_DEC_RS   = 4'd1,
    S_DEC_RT   = 4'd2,
    S_ADDR     = 4'd3,
    S_MEM_RD   = 4'd4,
    S_LD_WB    = 4'd5,
    S_MEM_WR   = 4'd6,
    S_R_EXEC   = 4'd7,
    S_R_WB     = 4'd8,
    S_BR_DONE  = 4'd9,
    S_JMP_DONE = 4'd10
  } state_t;

  typedef enum logic [2:0] {
    OC_RTYPE = 3'd0,
    OC_LOAD  = 3'd1,
    OC_STORE = 3'd2,
    OC_BEQ   = 3'd3,
    OC_JUMP  = 3'd4,
    OC_BAD   = 3'd5
  } opclass_t;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  localparam logic [1:0] BSRC_REG  = 2'b00;
  localparam logic [1:0] BSRC_FOUR = 2'b01;
  localparam logic [1:0] BSRC_IMM  = 2'b10;
  localparam logic [1:0] BSRC_SIMM = 2'b11;

  localparam logic [1:0] PCSRC_ALU  = 2'b00;
  localparam logic [1:0] PCSRC_OUT  = 2'b01;
  localparam logic [1:0] PCSRC_JUMP = 2'b10;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_load;
    logic       pc_load;
    logic       pc_load_cond;
    logic [1:0] pc_src;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       rf_wr;
    logic       rf_dst_sel;
    logic       rf_wdata_sel;
    logic       rd_idx_sel;
    logic       a_load;
    logic       b_load;
  } ctrl_t;

endpackage

// File: rtl/mcc_op_decode.sv
module mcc_op_decode
  import mcc_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OPC_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OPC_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OPC_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OPC_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OPC_JUMP  = 6'b000010
) (
  input  logic [OP_W-1:0] opcode,
  output opclass_t        opclass
);

  always_comb begin
    if (opcode == OPC_RTYPE)      opclass = OC_RTYPE;
    else if (opcode == OPC_LOAD)  opclass = OC_LOAD;
    else if (opcode == OPC_STORE) opclass = OC_STORE;
    else if (opcode == OPC_BEQ)   opclass = OC_BEQ;
    else if (opcode == OPC_JUMP)  opclass = OC_JUMP;
    else                          opclass = OC_BAD;
  end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_t   state_q,
  input  opclass_t opclass,
  output state_t   state_d
);

  always_comb begin
    state_d = S_FETCH;
    case (state_q)
      S_FETCH:  state_d = S_DEC_RS;
      // load needs only rs; every other code reads rt as well
      S_DEC_RS: state_d = (opclass == OC_LOAD) ? S_ADDR : S_DEC_RT;
      S_DEC_RT: begin
        case (opclass)
          OC_RTYPE: state_d = S_R_EXEC;
          OC_LOAD,
          OC_STORE: state_d = S_ADDR;
          OC_BEQ:   state_d = S_BR_DONE;
          OC_JUMP:  state_d = S_JMP_DONE;
          default:  state_d = S_FETCH;
        endcase
      end
      S_ADDR: begin
        if (opclass == OC_LOAD)       state_d = S_MEM_RD;
        else if (opclass == OC_STORE) state_d = S_MEM_WR;
        else                          state_d = S_FETCH;
      end
      S_MEM_RD: state_d = S_LD_WB;
      S_R_EXEC: state_d = S_R_WB;
      default:  state_d = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  state_t state,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (state)
      S_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.addr_sel  = 1'b0;
        ctrl.ir_load   = 1'b1;
        ctrl.pc_load   = 1'b1;
        ctrl.pc_src    = PCSRC_ALU;
        ctrl.alu_a_sel = 1'b0;
        ctrl.alu_b_sel = BSRC_FOUR;
        ctrl.alu_op    = ALU_ADD;
      end
      S_DEC_RS: begin
        ctrl.rd_idx_sel = 1'b0;
        ctrl.a_load     = 1'b1;
      end
      S_DEC_RT: begin
        ctrl.rd_idx_sel = 1'b1;
        ctrl.b_load     = 1'b1;
        ctrl.alu_a_sel  = 1'b0;
        ctrl.alu_b_sel  = BSRC_SIMM;
        ctrl.alu_op     = ALU_ADD;
      end
      S_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSRC_IMM;
        ctrl.alu_op    = ALU_ADD;
      end
      S_MEM_RD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      S_LD_WB: begin
        ctrl.rf_wr        = 1'b1;
        ctrl.rf_dst_sel   = 1'b0;
        ctrl.rf_wdata_sel = 1'b1;
      end
      S_MEM_WR: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      S_R_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSRC_REG;
        ctrl.alu_op    = ALU_FUNC;
      end
      S_R_WB: begin
        ctrl.rf_wr        = 1'b1;
        ctrl.rf_dst_sel   = 1'b1;
        ctrl.rf_wdata_sel = 1'b0;
      end
      S_BR_DONE: begin
        ctrl.alu_a_sel    = 1'b1;
        ctrl.alu_b_sel    = BSRC_REG;
        ctrl.alu_op       = ALU_SUB;
        ctrl.pc_load_cond = 1'b1;
        ctrl.pc_src       = PCSRC_OUT;
      end
      S_JMP_DONE: begin
        ctrl.pc_load = 1'b1;
        ctrl.pc_src  = PCSRC_JUMP;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OPC_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OPC_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OPC_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OPC_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OPC_JUMP  = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            addr_sel,
  output logic            ir_load,
  output logic            pc_load,
  output logic            pc_load_cond,
  output logic [1:0]      pc_src,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic [1:0]      alu_op,
  output logic            rf_wr,
  output logic            rf_dst_sel,
  output logic            rf_wdata_sel,
  output logic            rd_idx_sel,
  output logic            a_load,
  output logic            b_load
);

  opclass_t opclass;
  state_t   state_q, state_d, state_out;
  ctrl_t    ctrl_d, ctrl_q;

  mcc_op_decode #(
    .OP_W      (OP_W),
    .OPC_RTYPE (OPC_RTYPE),
    .OPC_LOAD  (OPC_LOAD),
    .OPC_STORE (OPC_STORE),
    .OPC_BEQ   (OPC_BEQ),
    .OPC_JUMP  (OPC_JUMP)
  ) u_op_decode (
    .opcode  (opcode),
    .opclass (opclass)
  );

  mcc_next_state u_next_state (
    .state_q (state_q),
    .opclass (opclass),
    .state_d (state_d)
  );

  // outputs are decoded from the state being entered, then registered
  assign state_out = rst ? S_FETCH : state_d;

  mcc_ctrl_decode u_ctrl_decode (
    .state (state_out),
    .ctrl  (ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_out;
    ctrl_q  <= ctrl_d;
  end

  assign mem_rd       = ctrl_q.mem_rd;
  assign mem_wr       = ctrl_q.mem_wr;
  assign addr_sel     = ctrl_q.addr_sel;
  assign ir_load      = ctrl_q.ir_load;
  assign pc_load      = ctrl_q.pc_load;
  assign pc_load_cond = ctrl_q.pc_load_cond;
  assign pc_src       = ctrl_q.pc_src;
  assign alu_a_sel    = ctrl_q.alu_a_sel;
  assign alu_b_sel    = ctrl_q.alu_b_sel;
  assign alu_op       = ctrl_q.alu_op;
  assign rf_wr        = ctrl_q.rf_wr;
  assign rf_dst_sel   = ctrl_q.rf_dst_sel;
  assign rf_wdata_sel = ctrl_q.rf_wdata_sel;
  assign rd_idx_sel   = ctrl_q.rd_idx_sel;
  assign a_load       = ctrl_q.a_load;
  assign b_load       = ctrl_q.b_load;

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_load && pc_load && mem_rd && !rf_wr && !mem_wr)); // R1
  AST_A_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    a_load |-> $past(ir_load)); // R3
  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
    b_load |-> ($past(a_load) && rd_idx_sel)); // R4
  AST_LOAD_SKIPS_RT: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |-> ($past(a_load, 2) && $past(alu_b_sel) == BSRC_IMM)); // R5
  AST_LOAD_WB_RETURN: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && rf_wdata_sel) |=> ir_load); // R5
  AST_STORE_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(alu_b_sel) == BSRC_IMM && $past(b_load, 2))); // R6
  AST_RTYPE_WB_RETURN: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && rf_dst_sel) |-> ($past(alu_op) == ALU_FUNC)); // R7
  AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (rst)
    pc_load_cond |=> ir_load); // R8
  AST_JUMP_RETURN: assert property (@(posedge clk) disable iff (rst)
    (pc_load && pc_src == PCSRC_JUMP) |=> ir_load); // R9
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11

endmodule

// File: tb/mcc_ctrl_fsm_tb.sv
module mcc_ctrl_fsm_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [5:0] OP_R   = 6'b000000;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_BQ  = 6'b000100;
  localparam logic [5:0] OP_J   = 6'b000010;
  localparam logic [5:0] OP_BAD = 6'b000001;
  localparam logic [5:0] OP_ONE = 6'b111111;

  // word: mem_rd mem_wr addr ir pc pcc pcsrc[2] asel bsel[2] op[2] rfw dst wsel rdsel aload bload
  localparam logic [18:0] W_F  = {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_D1 = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0};
  localparam logic [18:0] W_D2 = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,2'b11,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1};
  localparam logic [18:0] W_AD = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b1,2'b10,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_MR = {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_LD = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_MW = {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_EX = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b1,2'b00,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_RW = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,2'b00,2'b00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_BQ = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,1'b1,2'b00,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_JD = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b10,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};

  localparam int NVEC = 27;
  // entry: {requirement[3:0], opcode[5:0], expected word[18:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd2,  OP_LW,  W_F },  // R2 fetch
    {4'd3,  OP_LW,  W_D1},  // R3
    {4'd5,  OP_LW,  W_AD},  // R5 load skips rt read
    {4'd5,  OP_LW,  W_MR},  // R5
    {4'd5,  OP_LW,  W_LD},  // R5
    {4'd2,  OP_SW,  W_F },  // R2
    {4'd3,  OP_SW,  W_D1},  // R3
    {4'd4,  OP_SW,  W_D2},  // R4
    {4'd6,  OP_SW,  W_AD},  // R6
    {4'd6,  OP_SW,  W_MW},  // R6
    {4'd2,  OP_R,   W_F },  // R2
    {4'd3,  OP_R,   W_D1},  // R3
    {4'd4,  OP_R,   W_D2},  // R4
    {4'd7,  OP_R,   W_EX},  // R7
    {4'd7,  OP_R,   W_RW},  // R7
    {4'd2,  OP_BQ,  W_F },  // R2
    {4'd4,  OP_BQ,  W_D1},  // R4 path
    {4'd4,  OP_BQ,  W_D2},  // R4
    {4'd8,  OP_BQ,  W_BQ},  // R8
    {4'd9,  OP_J,   W_F },  // R9 path, fetch
    {4'd9,  OP_J,   W_D1},  // R9
    {4'd9,  OP_J,   W_D2},  // R9
    {4'd9,  OP_J,   W_JD},  // R9
    {4'd10, OP_BAD, W_F },  // R10
    {4'd10, OP_BAD, W_D1},  // R10
    {4'd10, OP_BAD, W_D2},  // R10
    {4'd11, OP_LW,  W_F }   // R11 back to fetch, no strobes
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_cond;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  logic alu_a_sel, rf_wr, rf_dst_sel, rf_wdata_sel, rd_idx_sel, a_load, b_load;
  logic [18:0] obs;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcc_ctrl_fsm u_dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_load(ir_load),
    .pc_load(pc_load), .pc_load_cond(pc_load_cond), .pc_src(pc_src),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel), .rf_wdata_sel(rf_wdata_sel),
    .rd_idx_sel(rd_idx_sel), .a_load(a_load), .b_load(b_load)
  );

  assign obs = {mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_cond, pc_src,
                alu_a_sel, alu_b_sel, alu_op, rf_wr, rf_dst_sel, rf_wdata_sel,
                rd_idx_sel, a_load, b_load};

  task automatic check(input logic [18:0] exp, input int req, input string what);
    n_chk++;
    if (obs !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, obs, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: fetch pattern is present while reset is held
    check(W_F, 1, "fetch during reset");
    rst = 1'b0;
    check(W_F, 1, "fetch after reset release");

    for (int i = 0; i < NVEC; i++) begin
      opcode = VEC[i][24:19];
      check(VEC[i][18:0], int'(VEC[i][28:25]), $sformatf("vector %0d", i));
      if (i != NVEC - 1) step();
    end

    // R5 then R1: reset during a load's memory read restarts at fetch
    step(); check(W_D1, 3, "load decode before reset");
    step(); check(W_AD, 5, "load address before reset");
    step(); check(W_MR, 5, "load read before reset");
    rst = 1'b1;
    step(); check(W_F, 1, "reset cuts load short");
    rst = 1'b0;
    check(W_F, 1, "fetch held after mid-run reset");
    step(); check(W_D1, 1, "decode follows mid-run reset");

    // R10: all-ones opcode also returns to fetch with no writes
    opcode = OP_ONE;
    step(); check(W_D2, 10, "unknown code reads rt");
    step(); check(W_F, 10, "unknown code back to fetch");
    step(); check(W_D1, 10, "next decode after unknown code");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule